// File: doc/BRIEF.md
# Rail and Thermal Fault Monitor

This block keeps watch over a board's supply rails and die temperatures and records the first fault it sees. Seven active-high power-good inputs, two bus-failure pulses (one for the analog companion chip, one for the clock chip) and three temperature readings with their own trip thresholds all feed one request vector indexed by error code. The lowest pending code is latched together with its fault class, and the block then holds it until a synchronous reset.

The latched 8-bit error code is also shown on a four-digit panel, in base 4: each digit is two bits of the code, carried in its own 4-bit nibble. A system controller reads the class to decide between shutdown and cooling action, and the panel gives a service technician a short number to look up.

Top module: `rail_thermal_fault_mon`

## Requirements
- R1: After reset `fault_class` is 0 (none), `fault_code` is 0x00, `panel_digits` is 16'h0000 and `fault_latched` is 0.
- R2: While `monitor_en` is 1, a low `rail_pg[i]` sampled at a clock edge latches class 1 (fatal) with code 0x01, 0x02, 0x03, 0x0B, 0x0D, 0x0E, 0x0F for i = 0..6; the result is visible after that edge.
- R3: While `monitor_en` is 0, the levels on `rail_pg` have no effect on any output.
- R4: A high `ana_bus_fail` latches fatal code 0x04; a high `clk_bus_fail` latches fatal code 0x0B.
- R5: When `temp_valid` is 1, a channel whose reading is strictly greater (unsigned) than its trip latches class 2 (thermal) with code 0x05, 0x06, 0x07 for channel 0, 1, 2; a reading equal to its trip does not trip.
- R6: When `temp_valid` is 1 and all three readings are zero, fatal code 0x0C is latched instead of any thermal fault.
- R7: When several fault sources are active in the same cycle, the lowest code is latched.
- R8: Once latched, code and class do not change on later faults until reset.
- R9: `panel_digits[4k+3:4k]` equals `{2'b00, fault_code[2k+1:2k]}` for k = 0..3, nibble 3 being the leftmost digit (0x04 shows 16'h0010, 0x0C shows 16'h0030).
- R10: `fault_latched` is 1 exactly when `fault_class` is not 0.

Bit k of `rail_pg` is rail k; channel c of `temp_rd` and `trip_cfg` occupies bits [8c+7:8c].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| monitor_en | input | 1 | Arms the rail checks |
| rail_pg | input | 7 | Active-high power-good, one per rail |
| ana_bus_fail | input | 1 | Failed transaction to analog companion chip |
| clk_bus_fail | input | 1 | Failed transaction to clock chip |
| temp_valid | input | 1 | Readings on temp_rd are fresh this cycle |
| temp_rd | input | 24 | Three unsigned 8-bit temperatures |
| trip_cfg | input | 24 | Three unsigned 8-bit trip thresholds |
| fault_latched | output | 1 | A fault has been recorded |
| fault_class | output | 2 | 0 none, 1 fatal, 2 thermal |
| fault_code | output | 8 | Latched error code |
| panel_digits | output | 16 | Four base-4 digits, one per nibble |

## Verification
Every fault source passes through one register, so a stimulus held across a clock edge shows up on code, class and flag right after that edge, and the panel follows the code with no further delay. The bench drives inputs on the falling edge, lets one rising edge capture them, restores benign inputs, and compares all four outputs on the next falling edge. Sticky behaviour is checked by a second stimulus one cycle later, compared one cycle after that against the first result.

// File: rtl/rtfm_pkg.sv
// Shared constants, types and code lookups for the rail/thermal fault monitor.
// Assumes error codes fit in the low four bits of the 8-bit code space.
package rtfm_pkg;
    localparam int CODE_W    = 8;
    localparam int TEMP_W    = 8;
    localparam int NUM_RAILS = 7;
    localparam int NUM_TEMPS = 3;
    localparam int NUM_CODES = 16;
    localparam int IDX_W     = $clog2(NUM_CODES);

    typedef enum logic [1:0] {
        FC_NONE    = 2'd0,
        FC_FATAL   = 2'd1,
        FC_THERMAL = 2'd2,
        FC_SEQ     = 2'd3
    } fclass_e;

    localparam logic [CODE_W-1:0] CODE_ANA_BUS    = 8'h04;
    localparam logic [CODE_W-1:0] CODE_THERM_BASE = 8'h05;
    localparam logic [CODE_W-1:0] CODE_CLK_BUS    = 8'h0B;
    localparam logic [CODE_W-1:0] CODE_TEMP_ZERO  = 8'h0C;

    // Fixed code per rail index
    function automatic logic [CODE_W-1:0] rail_code(input int idx);
        case (idx)
            0:       return 8'h01;
            1:       return 8'h02;
            2:       return 8'h03;
            3:       return 8'h0B;
            4:       return 8'h0D;
            5:       return 8'h0E;
            default: return 8'h0F;
        endcase
    endfunction

    // Class that a code belongs to
    function automatic fclass_e class_of(input logic [CODE_W-1:0] code);
        if (code == '0)
            return FC_NONE;
        if (code >= CODE_THERM_BASE && code < CODE_THERM_BASE + CODE_W'(NUM_TEMPS))
            return FC_THERMAL;
        return FC_FATAL;
    endfunction
endpackage

// File: rtl/rtfm_detect.sv
// Builds a request vector indexed by error code from all fault sources.
// Assumes inputs are already synchronous to clk; purely combinational.
module rtfm_detect
    import rtfm_pkg::*;
#(
    parameter int N_RAIL = NUM_RAILS,
    parameter int N_TEMP = NUM_TEMPS,
    parameter int TW     = TEMP_W,
    parameter int N_CODE = NUM_CODES
) (
    input  logic                 monitor_en,
    input  logic [N_RAIL-1:0]    rail_pg,
    input  logic                 ana_bus_fail,
    input  logic                 clk_bus_fail,
    input  logic                 temp_valid,
    input  logic [N_TEMP*TW-1:0] temp_rd,
    input  logic [N_TEMP*TW-1:0] trip_cfg,
    output logic [N_CODE-1:0]    req
);
    logic [N_RAIL-1:0] rail_drop;
    logic [N_TEMP-1:0] over_trip;
    logic              all_zero;

    assign rail_drop = monitor_en ? ~rail_pg : '0;
    assign all_zero  = ~|temp_rd;

    // One strict unsigned comparator per temperature channel
    for (genvar c = 0; c < N_TEMP; c++) begin : g_cmp
        assign over_trip[c] = temp_rd[c*TW +: TW] > trip_cfg[c*TW +: TW];
    end

    // Merge every source onto its code position
    always_comb begin
        for (int k = 0; k < N_CODE; k++) begin
            logic hit;
            hit = 1'b0;
            for (int r = 0; r < N_RAIL; r++)
                if (rail_drop[r] && rail_code(r) == CODE_W'(k))
                    hit = 1'b1;
            if (CODE_W'(k) == CODE_ANA_BUS && ana_bus_fail)
                hit = 1'b1;
            if (CODE_W'(k) == CODE_CLK_BUS && clk_bus_fail)
                hit = 1'b1;
            if (CODE_W'(k) == CODE_TEMP_ZERO && temp_valid && all_zero)
                hit = 1'b1;
            for (int c = 0; c < N_TEMP; c++)
                if (CODE_W'(k) == CODE_THERM_BASE + CODE_W'(c) &&
                    temp_valid && !all_zero && over_trip[c])
                    hit = 1'b1;
            req[k] = hit;
        end
    end
endmodule

// File: rtl/rtfm_prio.sv
// Lowest-index-wins priority encoder over the request vector.
// Assumes index 0 is never requested (code 0 means no fault).
module rtfm_prio #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    assign any = |req;

    // Scan from the top so the lowest set bit is the last written
    always_comb begin
        idx = '0;
        for (int k = N - 1; k >= 0; k--)
            if (req[k])
                idx = IW'(k);
    end
endmodule

// File: rtl/rtfm_panel.sv
// Renders a code as base-4 digits, two code bits per 4-bit panel nibble.
// Assumes the code width is even; digit DIGITS-1 is the leftmost.
module rtfm_panel #(
    parameter int CW = 8
) (
    input  logic [CW-1:0]       code,
    output logic [CW/2*4-1:0]   digits
);
    localparam int DIGITS = CW / 2;

    for (genvar d = 0; d < DIGITS; d++) begin : g_dig
        assign digits[4*d +: 4] = {2'b00, code[2*d +: 2]};
    end
endmodule

// File: rtl/rail_thermal_fault_mon.sv
// Top: detects rail, bus and temperature faults, latches the first one
// (lowest code on a tie) and holds it until synchronous reset.
// Assumes all inputs are synchronous to clk.
module rail_thermal_fault_mon
    import rtfm_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        monitor_en,
    input  logic [NUM_RAILS-1:0]        rail_pg,
    input  logic                        ana_bus_fail,
    input  logic                        clk_bus_fail,
    input  logic                        temp_valid,
    input  logic [NUM_TEMPS*TEMP_W-1:0] temp_rd,
    input  logic [NUM_TEMPS*TEMP_W-1:0] trip_cfg,
    output logic                        fault_latched,
    output logic [1:0]                  fault_class,
    output logic [CODE_W-1:0]           fault_code,
    output logic [CODE_W*2-1:0]         panel_digits
);
    logic [NUM_CODES-1:0] req;
    logic                 req_any;
    logic [IDX_W-1:0]     win_idx;
    logic [CODE_W-1:0]    win_code;

    rtfm_detect #(
        .N_RAIL (NUM_RAILS),
        .N_TEMP (NUM_TEMPS),
        .TW     (TEMP_W),
        .N_CODE (NUM_CODES)
    ) u_detect (
        .monitor_en   (monitor_en),
        .rail_pg      (rail_pg),
        .ana_bus_fail (ana_bus_fail),
        .clk_bus_fail (clk_bus_fail),
        .temp_valid   (temp_valid),
        .temp_rd      (temp_rd),
        .trip_cfg     (trip_cfg),
        .req          (req)
    );

    rtfm_prio #(
        .N  (NUM_CODES),
        .IW (IDX_W)
    ) u_prio (
        .req (req),
        .any (req_any),
        .idx (win_idx)
    );

    assign win_code = CODE_W'(win_idx);

    // First-fault latch: capture once, then hold until reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_latched <= 1'b0;
            fault_class   <= FC_NONE;
            fault_code    <= '0;
        end else if (!fault_latched && req_any) begin
            fault_latched <= 1'b1;
            fault_class   <= class_of(win_code);
            fault_code    <= win_code;
        end
    end

    rtfm_panel #(.CW(CODE_W)) u_panel (
        .code   (fault_code),
        .digits (panel_digits)
    );

    // R8
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_latched |=> ($stable(fault_code) && $stable(fault_class)));

    // R10
    flag_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_latched == (fault_class != FC_NONE));

    // R3
    rails_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault_latched && !monitor_en && !ana_bus_fail && !clk_bus_fail && !temp_valid)
        |=> !fault_latched);

    // R2
    rail_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault_latched && monitor_en && !rail_pg[0]) |=> (fault_code == 8'h01));

    // R5
    thermal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_class == FC_THERMAL) |-> (fault_code >= 8'h05 && fault_code <= 8'h07));
endmodule

// File: tb/tb_rail_thermal_fault_mon.sv
module tb_rail_thermal_fault_mon;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        monitor_en = 1'b0;
    logic [6:0]  rail_pg = 7'h7F;
    logic        ana_bus_fail = 1'b0;
    logic        clk_bus_fail = 1'b0;
    logic        temp_valid = 1'b0;
    logic [23:0] temp_rd = '0;
    logic [23:0] trip_cfg = '0;
    logic        fault_latched;
    logic [1:0]  fault_class;
    logic [7:0]  fault_code;
    logic [15:0] panel_digits;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    int seed  = 1234;

    always #5 clk = ~clk;

    rail_thermal_fault_mon dut (
        .clk(clk), .rst_n(rst_n), .monitor_en(monitor_en), .rail_pg(rail_pg),
        .ana_bus_fail(ana_bus_fail), .clk_bus_fail(clk_bus_fail),
        .temp_valid(temp_valid), .temp_rd(temp_rd), .trip_cfg(trip_cfg),
        .fault_latched(fault_latched), .fault_class(fault_class),
        .fault_code(fault_code), .panel_digits(panel_digits)
    );

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual cycle %0d expected end before 150000", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    function automatic logic [7:0] rail_tbl(input int i);
        logic [7:0] t [7] = '{8'h01, 8'h02, 8'h03, 8'h0B, 8'h0D, 8'h0E, 8'h0F};
        return t[i];
    endfunction

    // Expected code from one cycle of stimulus (R2..R7)
    function automatic logic [7:0] model(input logic en, input logic [6:0] pg,
                                         input logic ab, input logic cb, input logic tv,
                                         input logic [23:0] t, input logic [23:0] tr);
        logic [7:0] m = 8'hFF;
        if (en)
            for (int i = 0; i < 7; i++)
                if (!pg[i] && rail_tbl(i) < m) m = rail_tbl(i);
        if (ab && 8'h04 < m) m = 8'h04;
        if (cb && 8'h0B < m) m = 8'h0B;
        if (tv) begin
            if (t == 24'h0) begin
                if (8'h0C < m) m = 8'h0C;
            end else begin
                for (int c = 0; c < 3; c++)
                    if (t[c*8 +: 8] > tr[c*8 +: 8] && 8'(5 + c) < m) m = 8'(5 + c);
            end
        end
        return (m == 8'hFF) ? 8'h00 : m;
    endfunction

    function automatic logic [1:0] cls(input logic [7:0] c);
        if (c == 0) return 2'd0;
        if (c >= 8'h05 && c <= 8'h07) return 2'd2;
        return 2'd1;
    endfunction

    function automatic logic [15:0] pnl(input logic [7:0] c);
        return {2'b00, c[7:6], 2'b00, c[5:4], 2'b00, c[3:2], 2'b00, c[1:0]};
    endfunction

    task automatic check(input logic [7:0] ec, input string req);
        n_chk++;
        if (fault_code !== ec) begin
            n_bad++;
            $display("FAIL %s code: actual %h expected %h", req, fault_code, ec);
        end
        n_chk++;
        if (fault_class !== cls(ec)) begin
            n_bad++;
            $display("FAIL %s class: actual %0d expected %0d", req, fault_class, cls(ec));
        end
        n_chk++;
        if (panel_digits !== pnl(ec)) begin
            n_bad++;
            $display("FAIL R9 (%s) panel: actual %h expected %h", req, panel_digits, pnl(ec));
        end
        n_chk++;
        if (fault_latched !== (ec != 0)) begin
            n_bad++;
            $display("FAIL R10 (%s) flag: actual %b expected %b", req, fault_latched, ec != 0);
        end
    endtask

    task automatic benign();
        rail_pg = 7'h7F; ana_bus_fail = 0; clk_bus_fail = 0; temp_valid = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; benign();
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
    endtask

    // Apply one cycle of stimulus, restore, check after the capturing edge
    task automatic pulse(input logic en, input logic [6:0] pg, input logic ab,
                         input logic cb, input logic tv, input logic [23:0] t,
                         input logic [23:0] tr, input logic [7:0] ec, input string req);
        monitor_en = en; rail_pg = pg; ana_bus_fail = ab; clk_bus_fail = cb;
        temp_valid = tv; temp_rd = t; trip_cfg = tr;
        @(negedge clk);
        benign();
        @(negedge clk);
        check(ec, req);
    endtask

    initial begin
        void'($urandom(seed));
        do_reset();
        check(8'h00, "R1 reset");

        // Each rail alone (R2)
        for (int i = 0; i < 7; i++) begin
            do_reset();
            pulse(1, ~(7'(1) << i), 0, 0, 0, 24'h101010, 24'h808080, rail_tbl(i), "R2 rail");
        end
        // Rails masked (R3)
        do_reset();
        pulse(0, 7'h00, 0, 0, 0, 24'h0, 24'h0, 8'h00, "R3 masked");
        // Bus faults (R4), panel 0010 for 0x04 (R9)
        do_reset();
        pulse(0, 7'h7F, 1, 0, 0, 24'h0, 24'h0, 8'h04, "R4 ana bus");
        do_reset();
        pulse(0, 7'h7F, 0, 1, 0, 24'h0, 24'h0, 8'h0B, "R4 clk bus");
        // Thermal, equal does not trip (R5)
        do_reset();
        pulse(0, 7'h7F, 0, 0, 1, 24'h405060, 24'h405060, 8'h00, "R5 equal");
        do_reset();
        pulse(0, 7'h7F, 0, 0, 1, 24'h415060, 24'h405060, 8'h07, "R5 edram");
        do_reset();
        pulse(0, 7'h7F, 0, 0, 1, 24'h405161, 24'h405060, 8'h05, "R5 cpu+gpu");
        // All zero readings (R6), panel 0030
        do_reset();
        pulse(0, 7'h7F, 0, 0, 1, 24'h0, 24'h000000, 8'h0C, "R6 zero");
        // Same-cycle tie (R7)
        do_reset();
        pulse(1, 7'h7E, 1, 1, 1, 24'hFFFFFF, 24'h0, 8'h01, "R7 tie");
        // Sticky (R8)
        pulse(1, 7'h00, 1, 1, 1, 24'h0, 24'h0, 8'h01, "R8 sticky");

        // Constrained random
        for (int n = 0; n < 300; n++) begin
            logic        en, ab, cb, tv;
            logic [6:0]  pg;
            logic [23:0] t, tr;
            logic [7:0]  e1, e2;
            do_reset();
            en = 1'($urandom);
            for (int i = 0; i < 7; i++) pg[i] = ($urandom % 5) != 0;
            ab = ($urandom % 6) == 0;
            cb = ($urandom % 6) == 0;
            tv = 1'($urandom);
            tr = 24'($urandom);
            for (int c = 0; c < 3; c++) begin
                logic [7:0] tp;
                tp = tr[c*8 +: 8];
                case ($urandom % 4)
                    0: t[c*8 +: 8] = tp;
                    1: t[c*8 +: 8] = (tp == 8'hFF) ? tp : tp + 1;
                    2: t[c*8 +: 8] = (tp == 8'h00) ? tp : tp - 1;
                    default: t[c*8 +: 8] = 8'($urandom);
                endcase
            end
            if ($urandom % 8 == 0) t = '0;
            e1 = model(en, pg, ab, cb, tv, t, tr);
            pulse(en, pg, ab, cb, tv, t, tr, e1, "R7 random first fault");
            en = 1'($urandom); pg = 7'($urandom); ab = 1'($urandom); cb = 1'($urandom);
            tv = 1'($urandom); t = 24'($urandom);
            e2 = model(en, pg, ab, cb, tv, t, tr);
            pulse(en, pg, ab, cb, tv, t, tr, (e1 != 0) ? e1 : e2, "R8 random second");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule